// File: doc/BRIEF.md
# Copy and Fill Setup for a 2D Drawing Engine

This block prepares a rectangle operation for a 2D drawing engine. A request gives a source corner, a destination corner, a width, a height and a flag for 24-bit colour. The block then works out where the engine must begin and which way it must walk. A copy whose source and destination overlap must walk away from the region it has not read yet. To do that, the block moves the start corner to the right edge or the bottom row when needed and clears the matching forward-direction bit.

In 24-bit mode the engine counts in bytes, so every horizontal value is tripled. The engine also needs a byte-rotation phase, which the block derives from the destination start x. A fill request goes through the same path. A fill always walks forward, has no source corner, and produces a colour word made from the fill byte repeated three times.

A request is registered on its start strobe. A one-cycle done pulse follows on the next cycle. The results then hold until the next request that is accepted.

Top module: `blit_xfer_setup`

## Requirements
- R1: A start strobe with width or height equal to zero produces no done pulse and leaves every result output unchanged.
- R2: A start strobe with a non-zero width and height is registered. `done` is high for exactly the one cycle after that strobe, and all result outputs stay stable until the next accepted strobe.
- R3: When `mode24` is 1, source x, destination x and width are each multiplied by 3, and the product is truncated to 16 bits before any other step. When `mode24` is 0 they pass through unchanged.
- R4: For a copy where source y is less than destination y, both start y values become y + height - 1 (16-bit wrap) and `ctl[1]` (Y forward) is 0. Otherwise the y values are unchanged and `ctl[1]` is 1.
- R5: For a copy where the scaled source x is less than the scaled destination x, both start x values become x + width - 1 (16-bit wrap, scaled width) and `ctl[0]` (X forward) is 0. Otherwise they are unchanged and `ctl[0]` is 1.
- R6: In 24-bit mode with X forward, `ctl[10:8]` equals (dx / 4) mod 6, where dx is the final destination start x.
- R7: In 24-bit mode with X reversed, `ctl[10:8]` equals ((dx + 2) / 4) mod 6, where dx is the final destination start x.
- R8: `ctl[7]` is the rotation enable and equals `mode24`. When it is 0, `ctl[10:8]` is 0. All other `ctl` bits not named here are 0.
- R9: A fill request (`fill`=1) sets `ctl[1:0]` to 2'b11, sets `src_pos` to 0 and sets `fill_word` to {8'h00, b, b, b}, where b is `fill_byte`. A copy sets `fill_word` to 0.
- R10: `src_pos` and `dst_pos` carry x in bits 31:16 and y in bits 15:0. `size` carries the scaled width in bits 31:16 and the height in bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe |
| fill | input | 1 | 1 = solid fill, 0 = copy |
| mode24 | input | 1 | 24-bit colour mode |
| src_x | input | 16 | Source x |
| src_y | input | 16 | Source y |
| dst_x | input | 16 | Destination x |
| dst_y | input | 16 | Destination y |
| width | input | 16 | Width in pixels |
| height | input | 16 | Height in rows |
| fill_byte | input | 8 | Fill colour byte |
| done | output | 1 | One-cycle result pulse |
| src_pos | output | 32 | Source start {x, y} |
| dst_pos | output | 32 | Destination start {x, y} |
| size | output | 32 | {scaled width, height} |
| ctl | output | 12 | Direction bits, rotation enable and rotation code |
| fill_word | output | 32 | Replicated fill colour |

## Verification
The copy path is swept over every pairing of small source and destination corners, several widths and heights, and both modes. This covers all four combinations of overlap direction, as well as equal coordinates, which must stay forward. The 24-bit half of that sweep crosses every residue of the rotation code in both X directions, so the tests can tell the (dx+2) offset apart from plain division. Fills are swept over positions and colour bytes. Separate cases cover zero width, zero height and x values large enough that tripling wraps past 16 bits.

// File: rtl/blit_setup_pkg.sv
package blit_setup_pkg;
  localparam int CW = 16;
  localparam int RW = 3;
  localparam int CTL_W = 12;
  localparam int CTL_XF = 0;
  localparam int CTL_YF = 1;
  localparam int CTL_REN = 7;
  localparam int CTL_ROT = 8;

  // Triple a horizontal byte count in 24-bit mode, wrapping to CW bits.
  function automatic logic [CW-1:0] scale_h(input logic [CW-1:0] v, input logic m24);
    logic [CW+1:0] t;
    t = {2'b00, v} + {1'b0, v, 1'b0};
    return m24 ? t[CW-1:0] : v;
  endfunction

  // Rotation phase: quarter of the (offset) byte position, reduced mod 6.
  function automatic logic [RW-1:0] rot_phase(input logic [CW-1:0] dx, input logic fwd);
    logic [CW:0] s;
    logic [CW:0] q;
    s = {1'b0, dx} + (fwd ? {(CW+1){1'b0}} : (CW+1)'(2));
    q = s >> 2;
    return RW'(q % (CW+1)'(6));
  endfunction
endpackage

// File: rtl/blit_axis_orient.sv
module blit_axis_orient
  import blit_setup_pkg::*;
#(
  parameter int W = CW
) (
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] d_in,
  input  logic [W-1:0] len,
  input  logic         force_fwd,
  output logic [W-1:0] s_out,
  output logic [W-1:0] d_out,
  output logic         fwd
);
  logic [W-1:0] span;
  assign span  = len - W'(1);
  assign fwd   = force_fwd | ~(s_in < d_in);
  assign s_out = fwd ? s_in : s_in + span;
  assign d_out = fwd ? d_in : d_in + span;
endmodule

// File: rtl/blit_rot_calc.sv
module blit_rot_calc
  import blit_setup_pkg::*;
(
  input  logic [CW-1:0] dx,
  input  logic          fwd,
  input  logic          en,
  output logic [RW-1:0] rot
);
  assign rot = en ? rot_phase(dx, fwd) : '0;
endmodule

// File: rtl/blit_xfer_setup.sv
module blit_xfer_setup
  import blit_setup_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fill,
  input  logic          mode24,
  input  logic [15:0]   src_x,
  input  logic [15:0]   src_y,
  input  logic [15:0]   dst_x,
  input  logic [15:0]   dst_y,
  input  logic [15:0]   width,
  input  logic [15:0]   height,
  input  logic [7:0]    fill_byte,
  output logic          done,
  output logic [31:0]   src_pos,
  output logic [31:0]   dst_pos,
  output logic [31:0]   size,
  output logic [11:0]   ctl,
  output logic [31:0]   fill_word
);
  localparam int NAX = 2;

  logic          accept;
  logic          empty_req;
  logic [CW-1:0] w_adj;
  logic [CW-1:0] ax_s  [NAX];
  logic [CW-1:0] ax_d  [NAX];
  logic [CW-1:0] ax_l  [NAX];
  logic [CW-1:0] ax_so [NAX];
  logic [CW-1:0] ax_do [NAX];
  logic          ax_fwd[NAX];
  logic [RW-1:0] rot;
  logic [CTL_W-1:0] ctl_d;

  assign empty_req = (width == '0) | (height == '0);
  assign accept    = start & ~empty_req;
  assign w_adj     = scale_h(width, mode24);

  assign ax_s[0] = fill ? '0 : scale_h(src_x, mode24);
  assign ax_d[0] = scale_h(dst_x, mode24);
  assign ax_l[0] = w_adj;
  assign ax_s[1] = fill ? '0 : src_y;
  assign ax_d[1] = dst_y;
  assign ax_l[1] = height;

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    blit_axis_orient #(.W(CW)) u_axis (
      .s_in(ax_s[a]), .d_in(ax_d[a]), .len(ax_l[a]), .force_fwd(fill),
      .s_out(ax_so[a]), .d_out(ax_do[a]), .fwd(ax_fwd[a])
    );
  end

  blit_rot_calc u_rot (
    .dx(ax_do[0]), .fwd(ax_fwd[0]), .en(mode24), .rot(rot)
  );

  always_comb begin
    ctl_d = '0;
    ctl_d[CTL_XF] = ax_fwd[0];
    ctl_d[CTL_YF] = ax_fwd[1];
    ctl_d[CTL_REN] = mode24;
    ctl_d[CTL_ROT +: RW] = rot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      src_pos   <= '0;
      dst_pos   <= '0;
      size      <= '0;
      ctl       <= '0;
      fill_word <= '0;
    end else begin
      done <= accept;
      if (accept) begin
        src_pos   <= fill ? '0 : {ax_so[0], ax_so[1]};
        dst_pos   <= {ax_do[0], ax_do[1]};
        size      <= {w_adj, height};
        ctl       <= ctl_d;
        fill_word <= fill ? {8'h00, fill_byte, fill_byte, fill_byte} : '0;
      end
    end
  end
endmodule

// File: rtl/blit_xfer_setup_chk.sv
module blit_xfer_setup_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        fill,
  input logic        mode24,
  input logic [15:0] width,
  input logic [15:0] height,
  input logic        done,
  input logic [11:0] ctl,
  input logic [31:0] dst_pos
);
  p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(start) && $past(width) != 16'd0 && $past(height) != 16'd0));

  p_empty_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (width == 16'd0 || height == 16'd0)) |=> !done);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(ctl) && $stable(dst_pos)));

  p_rot_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[7] |-> (ctl[10:8] < 3'd6));

  p_rot_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(mode24)) |-> (ctl[10:7] == 4'd0));

  p_fill_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(fill)) |-> (ctl[1:0] == 2'b11));
endmodule

bind blit_xfer_setup blit_xfer_setup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .fill(fill), .mode24(mode24),
  .width(width), .height(height), .done(done), .ctl(ctl), .dst_pos(dst_pos)
);

// File: tb/blit_xfer_setup_tb_top.sv
`timescale 1ns/1ps
module blit_xfer_setup_tb_top;
  logic clk = 0, rst_n = 0;
  logic start = 0, fill = 0, mode24 = 0;
  logic [15:0] src_x = 0, src_y = 0, dst_x = 0, dst_y = 0, width = 0, height = 0;
  logic [7:0] fill_byte = 0;
  logic done;
  logic [31:0] src_pos, dst_pos, size, fill_word;
  logic [11:0] ctl;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  blit_xfer_setup dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fill(fill), .mode24(mode24),
    .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
    .width(width), .height(height), .fill_byte(fill_byte),
    .done(done), .src_pos(src_pos), .dst_pos(dst_pos), .size(size),
    .ctl(ctl), .fill_word(fill_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply one request; sample in the cycle after the strobe edge.
  task automatic run(input bit f, input bit m, input int sx, input int sy, input int dx,
                     input int dy, input int w, input int h, input int fb);
    int ux, vx, uw, esy, edy, esx, edx, q, rot;
    bit xf, yf;
    logic [31:0] old_dst;
    logic [11:0] old_ctl;
    @(negedge clk);
    old_dst = dst_pos; old_ctl = ctl;
    fill = f; mode24 = m; src_x = 16'(sx); src_y = 16'(sy); dst_x = 16'(dx);
    dst_y = 16'(dy); width = 16'(w); height = 16'(h); fill_byte = 8'(fb);
    start = 1;
    @(negedge clk);
    start = 0;
    if (w == 0 || h == 0) begin
      chk("R1 done", {31'd0, done}, 32'd0);
      chk("R1 dst_pos", dst_pos, old_dst);
      chk("R1 ctl", {20'd0, ctl}, {20'd0, old_ctl});
      return;
    end
    ux = m ? (sx * 3) % 65536 : sx;
    vx = m ? (dx * 3) % 65536 : dx;
    uw = m ? (w * 3) % 65536 : w;
    if (f) begin ux = 0; esy = 0; end else esy = sy;
    edy = dy;
    yf = f || !(sy < dy);
    if (!yf) begin esy = (sy + h - 1) % 65536; edy = (dy + h - 1) % 65536; end
    xf = f || !(ux < vx);
    esx = ux; edx = vx;
    if (!xf) begin esx = (ux + uw - 1) % 65536; edx = (vx + uw - 1) % 65536; end
    q = xf ? edx / 4 : (edx + 2) / 4;
    rot = m ? q % 6 : 0;
    chk("R2 done", {31'd0, done}, 32'd1);
    chk(f ? "R9 src_pos" : "R5 src_pos", src_pos, f ? 32'd0 : {16'(esx), 16'(esy)});
    chk("R4 dst_pos", dst_pos, {16'(edx), 16'(edy)});
    chk("R10 R3 size", size, {16'(uw), 16'(h)});
    chk(m ? (xf ? "R6 ctl" : "R7 ctl") : "R8 ctl", {20'd0, ctl},
        {20'd0, 1'b0, 3'(rot), m, 5'd0, yf, xf});
    chk("R9 fill_word", fill_word, f ? {8'h00, 8'(fb), 8'(fb), 8'(fb)} : 32'd0);
    @(negedge clk);
    chk("R2 pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    #200000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset done", {31'd0, done}, 32'd0);
    chk("R2 reset ctl", {20'd0, ctl}, 32'd0);
    rst_n = 1;
    for (int m = 0; m < 2; m++)
      for (int sx = 0; sx < 8; sx++)
        for (int dx = 0; dx < 8; dx++)
          for (int sy = 0; sy < 3; sy++)
            for (int dy = 0; dy < 3; dy++)
              for (int w = 1; w < 4; w++)
                run(0, m[0], sx, sy, dx, dy, w, 1 + (sx + dy) % 2, 0);
    for (int m = 0; m < 2; m++)
      for (int dx = 0; dx < 24; dx++)
        run(1, m[0], 5, 7, dx, dx % 5, 1 + dx % 4, 2, dx * 11);
    run(0, 0, 3, 4, 5, 6, 0, 3, 0);
    run(0, 1, 3, 4, 5, 6, 4, 0, 0);
    run(1, 1, 0, 0, 9, 9, 0, 0, 8'h5a);
    run(0, 1, 30000, 10, 30001, 20, 100, 5, 0);
    run(0, 1, 40000, 65535, 2, 3, 22000, 4, 0);
    run(1, 1, 0, 0, 65535, 65535, 65535, 1, 8'hff);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule